// File: doc/BRIEF.md
# Warp-Aware Cache Replacement Controller

This block keeps the replacement state of a small set-associative level-one data cache in a heavily multithreaded processor. Each set has an ordered recency list of way numbers. Position 0 is the most recently used (MRU) end and position `NUM_WAYS-1` is the least recently used (LRU) end. A hit moves the touched way to the MRU end. A miss picks a victim way and places the refilled line at a depth in the list. That depth comes from the issuing warp's scheduling rank and from whether the load was coherent or divergent.

A boundary, `part_lock_o`, splits every list into two regions. Positions below the boundary form a protected region near the MRU end. Positions at or beyond it form a replaceable region near the LRU end. Victims are taken only from the replaceable region. Ways that have a fill already in flight cannot be chosen. If no way in the replaceable region can be chosen, the request is reported as a bypass and no line is allocated.

The boundary moves at run time. The block counts hits and fills over a fixed window of accesses to a few sampled sets. When caching works well, the protected region grows. When caching works poorly, it shrinks.

Top module: `warp_repl_ctrl`

## Requirements
- R1: During and after reset, every list holds way p at position p, `part_lock_o` equals NUM_WAYS/2, and `vict_vld_o`, `vict_way_o`, `bypass_o` and `ins_depth_o` are all 0.
- R2: A request with `req_hit_i`=1 moves way `req_hit_way_i` to position 0 and shifts the entries that were above it down by one. In the next cycle `vict_vld_o`=0, `bypass_o`=0 and `ins_depth_o`=0.
- R3: On a miss, the raw insertion depth is 2*`req_rank_i`, plus 1 when `req_coherent_i`=0. Rank 0 is the highest priority, so higher priority and coherence both place the line nearer position 0.
- R4: The victim is the way at the deepest position p with p >= `part_lock_o` whose `pend_ways_i` bit is 0. A way in the protected region is never reported as a victim.
- R5: A way whose bit in `pend_ways_i` is 1 is never chosen. If no eligible way exists, the next cycle shows `bypass_o`=1, `vict_vld_o`=0, `vict_way_o`=0 and `ins_depth_o`=0, and the list is unchanged.
- R6: The applied depth is the raw depth raised to at least `part_lock_o` and limited to at most NUM_WAYS-1. The victim is moved to that position, and the entries between its old and new positions shift by one.
- R7: `vict_vld_o`, `vict_way_o`, `bypass_o` and `ins_depth_o` are registered and describe the request presented one clock earlier.
- R8: Sampled sets are those with index below SAMPLE_SETS. After every WINDOW accesses to sampled sets, the boundary rises by one if hits exceed HI_RATIO times fills. It falls by one if hits are below LO_RATIO times fills. A bypass counts as an access but not as a fill. The boundary always stays within 1 to NUM_WAYS-1.
- R9: Accesses to sets that are not sampled do not affect the boundary. A boundary change takes effect from the access after the one that completed the window.
- R10: Each set's list changes only on requests to that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A lookup result is presented this cycle |
| req_set_i | input | SET_W | Set index of the request |
| req_hit_i | input | 1 | 1 = hit, 0 = miss |
| req_hit_way_i | input | WAY_W | Way that hit (used only on a hit) |
| req_rank_i | input | RANK_W | Scheduling rank of the issuing warp, 0 = highest |
| req_coherent_i | input | 1 | 1 = coherent load, 0 = divergent load |
| pend_ways_i | input | NUM_WAYS | Per-way flag: a fill is already outstanding in this set |
| vict_vld_o | output | 1 | Previous miss allocated a victim |
| vict_way_o | output | WAY_W | Victim way of the previous miss |
| bypass_o | output | 1 | Previous miss found no eligible victim |
| ins_depth_o | output | WAY_W | List position given to the refilled line |
| part_lock_o | output | WAY_W | Current boundary: size of the protected region |

## Verification
The assertions check several properties on every cycle:
- Each list stays a permutation of the way numbers.
- A promoted way lands at position 0.
- A chosen victim lies at or beyond the boundary and is never a pending way.
- A bypass always follows a miss that had no eligible candidate, and never appears together with a victim.
- The reported depth lies between the boundary and the last position.
- The boundary moves by at most one step and stays inside its range.

Only the bench's scenarios can show the rest:
- Which victim a given history selects.
- How the entries between two positions shift.
- Whether coherent loads and higher-priority warps insert nearer the MRU end.
- When the window fires and in which direction it moves the boundary.
- That unsampled sets leave the boundary alone.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

  // Raw insertion depth: two positions per rank step, divergent loads one deeper.
  function automatic int unsigned raw_depth(input int unsigned rank, input logic coherent);
    return rank * 2 + (coherent ? 0 : 1);
  endfunction

  // Keep the fill inside the replaceable region and inside the list.
  function automatic int unsigned clamp_depth(input int unsigned raw, input int unsigned lock,
                                              input int unsigned ways);
    int unsigned d;
    d = raw;
    if (d < lock) d = lock;
    if (d > ways - 1) d = ways - 1;
    return d;
  endfunction

endpackage

// File: rtl/wrc_chain_store.sv
module wrc_chain_store #(
  parameter int NUM_SETS = 4,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SET_W-1:0]                  set_i,
  input  logic                              upd_en_i,
  input  logic [WAY_W-1:0]                  upd_from_i,
  input  logic [WAY_W-1:0]                  upd_to_i,
  output logic [NUM_WAYS-1:0][WAY_W-1:0]    rd_chain_o
);

  logic [NUM_WAYS-1:0][WAY_W-1:0] chain_q [NUM_SETS];
  logic [NUM_WAYS-1:0][WAY_W-1:0] nxt;
  logic [WAY_W-1:0]               moved_way;
  logic [NUM_WAYS-1:0]            used_ways;

  assign rd_chain_o = chain_q[set_i];
  assign moved_way  = rd_chain_o[upd_from_i];

  always_comb begin
    nxt = rd_chain_o;
    for (int p = 0; p < NUM_WAYS; p++) begin
      if (upd_from_i <= upd_to_i) begin
        if (p >= int'(upd_from_i) && p < int'(upd_to_i)) nxt[p] = rd_chain_o[WAY_W'(p + 1)];
      end else if (p > int'(upd_to_i) && p <= int'(upd_from_i)) begin
        nxt[p] = rd_chain_o[WAY_W'(p - 1)];
      end
    end
    nxt[upd_to_i] = moved_way;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int p = 0; p < NUM_WAYS; p++)
          chain_q[s][p] <= WAY_W'(p);
    end else if (upd_en_i) begin
      chain_q[set_i] <= nxt;
    end
  end

  always_comb begin
    used_ways = '0;
    for (int p = 0; p < NUM_WAYS; p++) used_ways[rd_chain_o[p]] = 1'b1;
  end

  // R10: the list of the addressed set stays a permutation of the ways
  a_r10_permutation: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(used_ways) == NUM_WAYS);

  // R2: a move to position 0 leaves the moved way at the MRU end
  a_r2_mru_landing: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en_i && upd_to_i == '0) |=> chain_q[$past(set_i)][0] == $past(moved_way));

endmodule

// File: rtl/wrc_victim_pick.sv
module wrc_victim_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] chain_i,
  input  logic [NUM_WAYS-1:0]            pend_i,
  input  logic [WAY_W-1:0]               lock_i,
  output logic                           found_o,
  output logic [WAY_W-1:0]               vpos_o,
  output logic [WAY_W-1:0]               vway_o
);

  // Scan from MRU to LRU; the last eligible slot wins, i.e. the deepest one.
  always_comb begin
    found_o = 1'b0;
    vpos_o  = '0;
    vway_o  = '0;
    for (int p = 0; p < NUM_WAYS; p++) begin
      if (p >= int'(lock_i) && !pend_i[chain_i[p]]) begin
        found_o = 1'b1;
        vpos_o  = WAY_W'(p);
        vway_o  = chain_i[p];
      end
    end
  end

  // R4: a chosen victim never sits in the protected region
  a_r4_in_thrash_region: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> vpos_o >= lock_i);

  // R5: a way with an outstanding fill is never chosen
  a_r5_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> !pend_i[vway_o]);

endmodule

// File: rtl/wrc_part_tuner.sv
module wrc_part_tuner #(
  parameter int NUM_WAYS = 4,
  parameter int WINDOW   = 8,
  parameter int HI_RATIO = 2,
  parameter int LO_RATIO = 1,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int CNT_W = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en_i,
  input  logic             acc_hit_i,
  input  logic             acc_fill_i,
  output logic [WAY_W-1:0] lock_o
);

  localparam logic [WAY_W-1:0] LOCK_MIN  = WAY_W'(1);
  localparam logic [WAY_W-1:0] LOCK_MAX  = WAY_W'(NUM_WAYS - 1);
  localparam logic [WAY_W-1:0] LOCK_INIT = WAY_W'(NUM_WAYS / 2);

  logic [CNT_W-1:0] acc_cnt, hit_cnt, fill_cnt;
  logic [CNT_W-1:0] hit_n, fill_n;
  logic             window_end, widen, narrow;

  assign hit_n      = hit_cnt + CNT_W'(acc_hit_i);
  assign fill_n     = fill_cnt + CNT_W'(acc_fill_i);
  assign window_end = acc_en_i && (acc_cnt == CNT_W'(WINDOW - 1));
  assign widen      = window_end && (32'(hit_n) > HI_RATIO * 32'(fill_n));
  assign narrow     = window_end && (32'(hit_n) < LO_RATIO * 32'(fill_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      hit_cnt  <= '0;
      fill_cnt <= '0;
      lock_o   <= LOCK_INIT;
    end else if (acc_en_i) begin
      if (window_end) begin
        acc_cnt  <= '0;
        hit_cnt  <= '0;
        fill_cnt <= '0;
        if (widen && lock_o < LOCK_MAX) lock_o <= lock_o + 1'b1;
        else if (narrow && lock_o > LOCK_MIN) lock_o <= lock_o - 1'b1;
      end else begin
        acc_cnt  <= acc_cnt + 1'b1;
        hit_cnt  <= hit_n;
        fill_cnt <= fill_n;
      end
    end
  end

  // R8: boundary stays inside its range
  a_r8_lock_range: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o >= LOCK_MIN && lock_o <= LOCK_MAX);

  // R8: boundary moves by at most one step
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o != $past(lock_o) |-> (lock_o == $past(lock_o) + 1'b1 || lock_o + 1'b1 == $past(lock_o)));

  // R9: boundary only moves when a sampled window closes
  a_r9_only_at_window: assert property (@(posedge clk) disable iff (!rst_n)
    !window_end |=> $stable(lock_o));

endmodule

// File: rtl/warp_repl_ctrl.sv
module warp_repl_ctrl #(
  parameter int NUM_SETS    = 4,
  parameter int NUM_WAYS    = 4,
  parameter int RANK_W      = 2,
  parameter int SAMPLE_SETS = 1,
  parameter int WINDOW      = 8,
  parameter int HI_RATIO    = 2,
  parameter int LO_RATIO    = 1,
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid_i,
  input  logic [SET_W-1:0]    req_set_i,
  input  logic                req_hit_i,
  input  logic [WAY_W-1:0]    req_hit_way_i,
  input  logic [RANK_W-1:0]   req_rank_i,
  input  logic                req_coherent_i,
  input  logic [NUM_WAYS-1:0] pend_ways_i,
  output logic                vict_vld_o,
  output logic [WAY_W-1:0]    vict_way_o,
  output logic                bypass_o,
  output logic [WAY_W-1:0]    ins_depth_o,
  output logic [WAY_W-1:0]    part_lock_o
);
  import wrc_pkg::*;

  logic [NUM_WAYS-1:0][WAY_W-1:0] chain;
  logic             hit_req, miss_req, found, alloc, no_candidate;
  logic [WAY_W-1:0] hit_pos, vpos, vway, depth;
  logic [WAY_W-1:0] upd_from, upd_to;
  logic             sampled;

  assign hit_req      = req_valid_i && req_hit_i;
  assign miss_req     = req_valid_i && !req_hit_i;
  assign alloc        = miss_req && found;
  assign no_candidate = miss_req && !found;
  assign sampled      = req_valid_i && (32'(req_set_i) < SAMPLE_SETS);

  always_comb begin
    hit_pos = '0;
    for (int p = 0; p < NUM_WAYS; p++)
      if (chain[p] == req_hit_way_i) hit_pos = WAY_W'(p);
  end

  assign depth = WAY_W'(clamp_depth(raw_depth(32'(req_rank_i), req_coherent_i),
                                    32'(part_lock_o), NUM_WAYS));

  assign upd_from = hit_req ? hit_pos : vpos;
  assign upd_to   = hit_req ? '0 : depth;

  wrc_chain_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (req_set_i),
    .upd_en_i   (hit_req || alloc),
    .upd_from_i (upd_from),
    .upd_to_i   (upd_to),
    .rd_chain_o (chain)
  );

  wrc_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .chain_i (chain),
    .pend_i  (pend_ways_i),
    .lock_i  (part_lock_o),
    .found_o (found),
    .vpos_o  (vpos),
    .vway_o  (vway)
  );

  wrc_part_tuner #(.NUM_WAYS(NUM_WAYS), .WINDOW(WINDOW),
                   .HI_RATIO(HI_RATIO), .LO_RATIO(LO_RATIO)) u_tuner (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en_i   (sampled),
    .acc_hit_i  (hit_req),
    .acc_fill_i (alloc),
    .lock_o     (part_lock_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vict_vld_o  <= 1'b0;
      vict_way_o  <= '0;
      bypass_o    <= 1'b0;
      ins_depth_o <= '0;
    end else begin
      vict_vld_o  <= alloc;
      vict_way_o  <= alloc ? vway : '0;
      bypass_o    <= no_candidate;
      ins_depth_o <= alloc ? depth : '0;
    end
  end

  // R5: bypass and victim are exclusive
  a_r5_bypass_excl: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_o |-> !vict_vld_o);

  // R7: a miss with no candidate is reported as bypass one cycle later
  a_r7_bypass_timing: assert property (@(posedge clk) disable iff (!rst_n)
    no_candidate |=> bypass_o);

  // R6: reported depth lies between the boundary used and the last position
  a_r6_depth_range: assert property (@(posedge clk) disable iff (!rst_n)
    vict_vld_o |-> (ins_depth_o >= $past(part_lock_o) && 32'(ins_depth_o) <= NUM_WAYS - 1));

  // R2: a hit never produces a victim or a bypass
  a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hit_req |=> (!vict_vld_o && !bypass_o));

endmodule

// File: tb/warp_repl_ctrl_test.sv
`timescale 1ns/1ps
module warp_repl_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_set = '0;
  logic       req_hit = 1'b0;
  logic [1:0] req_hit_way = '0;
  logic [1:0] req_rank = '0;
  logic       req_coh = 1'b0;
  logic [3:0] pend = '0;
  logic       vict_vld, bypass;
  logic [1:0] vict_way, ins_depth, part_lock;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  warp_repl_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_set_i(req_set),
    .req_hit_i(req_hit), .req_hit_way_i(req_hit_way), .req_rank_i(req_rank),
    .req_coherent_i(req_coh), .pend_ways_i(pend), .vict_vld_o(vict_vld),
    .vict_way_o(vict_way), .bypass_o(bypass), .ins_depth_o(ins_depth),
    .part_lock_o(part_lock)
  );

  typedef struct packed {
    logic [1:0] set;
    logic       hit;
    logic [1:0] hway;
    logic [1:0] rank;
    logic       coh;
    logic [3:0] pend;
    logic       e_vld;
    logic [1:0] e_way;
    logic       e_byp;
    logic [1:0] e_dep;
  } vec_t;

  // Boundary is 2 throughout; lists shown MRU..LRU after each entry.
  localparam vec_t TBL [14] = '{
    '{2'd1,1'b0,2'd0,2'd0,1'b1,4'b0000, 1'b1,2'd3,1'b0,2'd2}, // [0,1,3,2]
    '{2'd1,1'b0,2'd0,2'd1,1'b0,4'b0000, 1'b1,2'd2,1'b0,2'd3}, // [0,1,3,2]
    '{2'd1,1'b1,2'd2,2'd0,1'b0,4'b0000, 1'b0,2'd0,1'b0,2'd0}, // hit -> [2,0,1,3]
    '{2'd1,1'b0,2'd0,2'd1,1'b1,4'b1000, 1'b1,2'd1,1'b0,2'd2}, // way3 pending
    '{2'd1,1'b0,2'd0,2'd3,1'b0,4'b1010, 1'b0,2'd0,1'b1,2'd0}, // none -> bypass
    '{2'd1,1'b0,2'd0,2'd3,1'b1,4'b0000, 1'b1,2'd3,1'b0,2'd3}, // depth 6 -> 3
    '{2'd1,1'b1,2'd3,2'd0,1'b0,4'b0000, 1'b0,2'd0,1'b0,2'd0}, // hit -> [3,2,0,1]
    '{2'd1,1'b0,2'd0,2'd0,1'b0,4'b0000, 1'b1,2'd1,1'b0,2'd2}, // -> [3,2,1,0]
    '{2'd1,1'b0,2'd0,2'd0,1'b1,4'b0001, 1'b1,2'd1,1'b0,2'd2},
    '{2'd1,1'b0,2'd0,2'd2,1'b0,4'b0000, 1'b1,2'd0,1'b0,2'd3},
    '{2'd2,1'b0,2'd0,2'd0,1'b1,4'b0000, 1'b1,2'd3,1'b0,2'd2}, // other set untouched
    '{2'd1,1'b1,2'd1,2'd0,1'b0,4'b0000, 1'b0,2'd0,1'b0,2'd0}, // hit -> [1,3,2,0]
    '{2'd1,1'b0,2'd0,2'd0,1'b1,4'b0000, 1'b1,2'd0,1'b0,2'd2}, // -> [1,3,0,2]
    '{2'd1,1'b0,2'd0,2'd0,1'b1,4'b0000, 1'b1,2'd2,1'b0,2'd2}  // shift seen
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; outputs are read at the following falling edge.
  task automatic acc(input logic [1:0] s, input logic h, input logic [1:0] hw,
                     input logic [1:0] rk, input logic c, input logic [3:0] pm);
    req_valid = 1'b1; req_set = s; req_hit = h; req_hit_way = hw;
    req_rank = rk; req_coh = c; pend = pm;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state (held in reset)
    chk("R1 vict_vld", int'(vict_vld), 0);
    chk("R1 bypass", int'(bypass), 0);
    chk("R1 lock", int'(part_lock), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 depth", int'(ins_depth), 0);
    chk("R1 way", int'(vict_way), 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < 14; i++) begin
      acc(TBL[i].set, TBL[i].hit, TBL[i].hway, TBL[i].rank, TBL[i].coh, TBL[i].pend);
      chk($sformatf("R5 vld v%0d", i), int'(vict_vld), int'(TBL[i].e_vld));
      chk($sformatf("R4 way v%0d", i), int'(vict_way), int'(TBL[i].e_way));
      chk($sformatf("R7 bypass v%0d", i), int'(bypass), int'(TBL[i].e_byp));
      chk($sformatf("R3 R6 depth v%0d", i), int'(ins_depth), int'(TBL[i].e_dep));
    end

    // R8 widen: 7 hits + 1 fill on sampled set 0 (list [0,1,2,3])
    for (int i = 0; i < 7; i++) acc(2'd0, 1'b1, 2'd0, 2'd0, 1'b0, 4'b0000);
    chk("R9 lock before window", int'(part_lock), 2);
    acc(2'd0, 1'b0, 2'd0, 2'd0, 1'b1, 4'b0000);
    chk("R9 depth uses old boundary", int'(ins_depth), 2);
    chk("R8 widen", int'(part_lock), 3);
    // set 1 list [1,3,2,0]; only position 3 replaceable now
    acc(2'd1, 1'b0, 2'd0, 2'd0, 1'b1, 4'b0000);
    chk("R6 clamp to new boundary", int'(ins_depth), 3);
    chk("R4 victim with boundary 3", int'(vict_way), 0);

    // R8 narrow: windows of 8 fills
    for (int w = 0; w < 3; w++) begin
      for (int i = 0; i < 8; i++) acc(2'd0, 1'b0, 2'd0, 2'd3, 1'b1, 4'b0000);
      chk($sformatf("R8 narrow w%0d", w), int'(part_lock), (w == 0) ? 2 : 1);
    end

    // R9 unsampled set leaves boundary alone
    for (int i = 0; i < 8; i++) acc(2'd3, 1'b1, 2'd1, 2'd0, 1'b0, 4'b0000);
    for (int i = 0; i < 8; i++) acc(2'd3, 1'b0, 2'd0, 2'd0, 1'b0, 4'b0000);
    chk("R9 unsampled", int'(part_lock), 1);

    // R8 widen to the cap
    for (int w = 0; w < 3; w++) begin
      for (int i = 0; i < 8; i++) acc(2'd0, 1'b1, 2'd2, 2'd0, 1'b0, 4'b0000);
      chk($sformatf("R8 widen w%0d", w), int'(part_lock), (w == 0) ? 2 : 3);
    end

    // R2 hit on set 0 produces no victim
    acc(2'd0, 1'b1, 2'd1, 2'd0, 1'b0, 4'b0000);
    chk("R2 hit no victim", int'(vict_vld), 0);

    finish_run();
  end

endmodule